// File: doc/BRIEF.md
# Shared-Memory Port Collision Arbiter

This block watches the two independent access ports of a dual-ported memory, called left and right. Each port has an enable, a write strobe and an address. It is a clocked arbiter. A collision exists when both ports are enabled and present the same address. When a collision starts, the arbiter grants the location to the port that got there first and marks the other port as the loser. The loser then sees an active-low busy flag, its write strobe is blocked before it reaches the array, and a read-hold signal tells the loser's read-data register to keep its present contents.

Priority depends on which event completed the match. When one port's enable rose onto an address that was already equal, the port that was enabled earlier wins. When both ports were already enabled and an address change made the addresses equal, the port whose address was already in place wins. If both ports had such an event in the same cycle, the arbiter treats it as a tie and the left port wins. The winner is stored at the start of the collision and is kept until the collision ends.

In slave mode the block does no arbitration of its own. A per-port busy input, driven by a master arbiter elsewhere, decides which port loses, and the local busy outputs stay inactive. All pins are plain level controls sampled on the rising clock edge. The block has no data stream, so no valid/ready handshake applies and there is no back-pressure.

Top module: `dpcoll_arb`

## Requirements
- R1: A port's busy output goes low only in the cycle after an edge at which both enables were high and both addresses were equal. Otherwise both busy outputs stay high.
- R2: Take a collision that starts because one port's enable rose while the addresses were already equal and the other port was already enabled. The port that was already enabled wins. The port whose enable rose gets busy low after that edge.
- R3: Take a collision that starts because one port's address changed to equal the other port's unchanged address, with both ports enabled. The port whose address did not change wins.
- R4: After an edge where the match is gone (an address differs or either enable is low), both busy outputs are high.
- R5: When both ports have an arrival event (enable rise or address change) in the cycle the match begins, or neither does, the left port wins.
- R6: While the match holds without a break, the winner does not change, whatever the strobes do. A new decision is made only after the match has been absent for at least one edge.
- R7: Busy is active low. After reset both busy outputs are high. The two busy outputs are never low together.
- R8: Write-through (`l_wr_go`/`r_wr_go`) is high exactly when that port is enabled, is strobing a write, and is not the loser in the current cycle. In master mode a loser's write is blocked from the very first cycle of the collision.
- R9: With `slave_mode` high, a low `l_busy_in_n`/`r_busy_in_n` blocks that port's write-through. Both busy outputs are high from the edge after `slave_mode` is sampled high.
- R10: Read-hold (`l_rd_hold`/`r_rd_hold`) is high while a port is the loser. It is low in any cycle in which the loser changes its address, enable or write strobe compared with the previous edge. It is low whenever the port is not the loser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| slave_mode | input | 1 | 1: losers taken from the busy inputs; 0: local arbitration |
| l_en | input | 1 | Left port enable, active high |
| l_we | input | 1 | Left port write strobe, active high |
| l_addr | input | AW | Left port address |
| l_busy_in_n | input | 1 | Left busy from a master arbiter, active low (slave mode) |
| r_en | input | 1 | Right port enable, active high |
| r_we | input | 1 | Right port write strobe, active high |
| r_addr | input | AW | Right port address |
| r_busy_in_n | input | 1 | Right busy from a master arbiter, active low (slave mode) |
| l_busy_n | output | 1 | Registered busy toward the left port, active low |
| r_busy_n | output | 1 | Registered busy toward the right port, active low |
| l_wr_go | output | 1 | Left write allowed to reach the array this cycle |
| r_wr_go | output | 1 | Right write allowed to reach the array this cycle |
| l_rd_hold | output | 1 | Left read-data register must keep its value |
| r_rd_hold | output | 1 | Right read-data register must keep its value |

## Verification
A wrong stored winner shows up one edge after it is latched: the busy flag is low on the wrong port. In the same cycle the write-through and read-hold pins point at the wrong port, because they use the same decision without the register delay. A stale previous-sample register breaks arrival detection. That breaks priority only in the cycle the match begins, so the sweep changes both ports' enables and addresses at random and compares every cycle against a model of the priority rules. A collision flag that fails to clear leaves busy stuck low after the match ends. The release check catches this one edge later.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;
  localparam int NPORT = 2;
endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  output logic          arrive,
  output logic          toggle
);
  logic          en_q;
  logic          we_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      we_q   <= we;
      addr_q <= addr;
    end
  end

  // an arrival is what can complete a match this cycle
  assign arrive = (en & ~en_q) | (addr != addr_q);
  // any change the loser makes that lets its read data move on
  assign toggle = (en != en_q) | (we != we_q) | (addr != addr_q);
endmodule

// File: rtl/dpa_decide.sv
module dpa_decide
  import dpa_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slave_mode,
  input  logic          l_en,
  input  logic [AW-1:0] l_addr,
  input  logic          l_arrive,
  input  logic          r_en,
  input  logic [AW-1:0] r_addr,
  input  logic          r_arrive,
  output logic          match,
  output logic          lose_l,
  output logic          lose_r
);
  logic  coll_q;
  side_e win_q;
  side_e win_new;
  side_e win_now;

  assign match = l_en & r_en & (l_addr == r_addr);

  // only the left moved: the right was in place first and wins
  assign win_new = (l_arrive & ~r_arrive) ? SIDE_R : SIDE_L;
  assign win_now = coll_q ? win_q : win_new;

  always_comb begin
    lose_l = 1'b0;
    lose_r = 1'b0;
    if (!slave_mode && match) begin
      lose_l = (win_now == SIDE_R);
      lose_r = (win_now == SIDE_L);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      coll_q <= 1'b0;
      win_q  <= SIDE_L;
    end else begin
      coll_q <= ~slave_mode & match;
      if (match) win_q <= win_now;
    end
  end

  // R6
  winner_held_chk: assert property (@(posedge clk) disable iff (rst)
    (coll_q && match && !slave_mode) |=> (win_q == $past(win_q)));

  // R7
  one_loser_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lose_l, lose_r}));
endmodule

// File: rtl/dpa_port_gate.sv
module dpa_port_gate (
  input  logic clk,
  input  logic rst,
  input  logic slave_mode,
  input  logic en,
  input  logic we,
  input  logic toggle,
  input  logic lose_local,
  input  logic busy_in_n,
  output logic wr_go,
  output logic rd_hold,
  output logic busy_n
);
  logic lose_eff;

  assign lose_eff = slave_mode ? ~busy_in_n : lose_local;
  assign wr_go    = en & we & ~lose_eff;
  assign rd_hold  = lose_eff & ~toggle;

  always_ff @(posedge clk) begin
    if (rst) busy_n <= 1'b1;
    else     busy_n <= slave_mode | ~lose_local;
  end

  // R8
  wr_pass_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> busy_n);

  // R9
  slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    slave_mode |=> busy_n);
endmodule

// File: rtl/dpcoll_arb.sv
module dpcoll_arb
  import dpa_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slave_mode,
  input  logic          l_en,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic          l_busy_in_n,
  input  logic          r_en,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic          r_busy_in_n,
  output logic          l_busy_n,
  output logic          r_busy_n,
  output logic          l_wr_go,
  output logic          r_wr_go,
  output logic          l_rd_hold,
  output logic          r_rd_hold
);
  logic [NPORT-1:0] en_a, we_a, bin_a, arr_a, tog_a, lose_a;
  logic [NPORT-1:0] go_a, hold_a, busy_a;
  logic [AW-1:0]    addr_a [NPORT];
  logic             match;

  assign en_a      = {r_en, l_en};
  assign we_a      = {r_we, l_we};
  assign bin_a     = {r_busy_in_n, l_busy_in_n};
  assign addr_a[0] = l_addr;
  assign addr_a[1] = r_addr;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpa_port_track #(.AW(AW)) u_trk (
      .clk(clk), .rst(rst), .en(en_a[p]), .we(we_a[p]), .addr(addr_a[p]),
      .arrive(arr_a[p]), .toggle(tog_a[p])
    );
    dpa_port_gate u_gate (
      .clk(clk), .rst(rst), .slave_mode(slave_mode), .en(en_a[p]),
      .we(we_a[p]), .toggle(tog_a[p]), .lose_local(lose_a[p]),
      .busy_in_n(bin_a[p]), .wr_go(go_a[p]), .rd_hold(hold_a[p]),
      .busy_n(busy_a[p])
    );
  end

  dpa_decide #(.AW(AW)) u_dec (
    .clk(clk), .rst(rst), .slave_mode(slave_mode),
    .l_en(l_en), .l_addr(l_addr), .l_arrive(arr_a[0]),
    .r_en(r_en), .r_addr(r_addr), .r_arrive(arr_a[1]),
    .match(match), .lose_l(lose_a[0]), .lose_r(lose_a[1])
  );

  assign l_busy_n  = busy_a[0];
  assign r_busy_n  = busy_a[1];
  assign l_wr_go   = go_a[0];
  assign r_wr_go   = go_a[1];
  assign l_rd_hold = hold_a[0];
  assign r_rd_hold = hold_a[1];

  // R7
  busy_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    l_busy_n || r_busy_n);

  // R1
  busy_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
    (!l_busy_n || !r_busy_n) |-> $past(l_en && r_en && (l_addr == r_addr)));

  // R4
  release_chk: assert property (@(posedge clk) disable iff (rst)
    !match |=> (l_busy_n && r_busy_n));
endmodule

// File: tb/dpcoll_arb_test.sv
module dpcoll_arb_test;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slave_mode = 1'b0;
  logic l_en = 0, l_we = 0, l_busy_in_n = 1, r_en = 0, r_we = 0, r_busy_in_n = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy_n, r_busy_n, l_wr_go, r_wr_go, l_rd_hold, r_rd_hold;

  int n_chk = 0, n_bad = 0;

  // model state
  logic pen_l = 0, pwe_l = 0, pen_r = 0, pwe_r = 0;
  logic [AW-1:0] pad_l = '0, pad_r = '0;
  logic mcoll = 0, mwin_r = 0;

  dpcoll_arb #(.AW(AW)) uut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  task automatic apply(input logic le, lw, input logic [AW-1:0] la,
                       input logic re, rw, input logic [AW-1:0] ra,
                       input logic lbi, rbi, sm, input string tag);
    logic m, evl, evr, decr, lsl, lsr, tgl, tgr;
    l_en = le; l_we = lw; l_addr = la; r_en = re; r_we = rw; r_addr = ra;
    l_busy_in_n = lbi; r_busy_in_n = rbi; slave_mode = sm;
    #1;
    m    = le & re & (la == ra);
    evl  = (le & ~pen_l) | (la != pad_l);
    evr  = (re & ~pen_r) | (ra != pad_r);
    decr = evl & ~evr;
    if (sm)        begin lsl = ~lbi; lsr = ~rbi; end
    else if (!m)   begin lsl = 0; lsr = 0; end
    else if (mcoll) begin lsl = mwin_r; lsr = ~mwin_r; end
    else           begin lsl = decr; lsr = ~decr; end
    tgl = (la != pad_l) | (le != pen_l) | (lw != pwe_l);
    tgr = (ra != pad_r) | (re != pen_r) | (rw != pwe_r);
    chk(tag, "l_wr_go", l_wr_go, le & lw & ~lsl);
    chk(tag, "r_wr_go", r_wr_go, re & rw & ~lsr);
    chk(tag, "l_rd_hold", l_rd_hold, lsl & ~tgl);
    chk(tag, "r_rd_hold", r_rd_hold, lsr & ~tgr);
    @(posedge clk);
    if (m && !sm && !mcoll) mwin_r = decr;
    mcoll = ~sm & m;
    pen_l = le; pwe_l = lw; pad_l = la; pen_r = re; pwe_r = rw; pad_r = ra;
    #1;
    chk(tag, "l_busy_n", l_busy_n, sm | ~lsl);
    chk(tag, "r_busy_n", r_busy_n, sm | ~lsr);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7 reset state
    #1 chk("R7", "l_busy_n reset", l_busy_n, 1'b1);
    chk("R7", "r_busy_n reset", r_busy_n, 1'b1);
    @(negedge clk);
    // R1: no collision on different addresses or one port disabled
    apply(1,0,2'd1, 1,0,2'd2, 1,1,0, "R1");
    apply(1,0,2'd2, 0,0,2'd2, 1,1,0, "R1");
    // R2: left already on, right enable rises onto same address -> right loses
    apply(1,0,2'd2, 1,0,2'd2, 1,1,0, "R2");
    chk("R2", "r_busy_n low", r_busy_n, 1'b0);
    // R8/R10: loser write blocked, read held, winner writes
    apply(1,1,2'd2, 1,1,2'd2, 1,1,0, "R8");
    apply(1,1,2'd2, 1,1,2'd2, 1,1,0, "R10");
    chk("R10", "r_rd_hold steady", r_rd_hold, 1'b1);
    apply(1,1,2'd2, 1,0,2'd2, 1,1,0, "R10");
    // R6: winner held while strobes move
    apply(1,0,2'd2, 1,1,2'd2, 1,1,0, "R6");
    chk("R6", "r_busy_n held", r_busy_n, 1'b0);
    // R4: release on enable drop
    apply(0,0,2'd2, 1,0,2'd2, 1,1,0, "R4");
    chk("R4", "l_busy_n released", l_busy_n, 1'b1);
    // R2 mirror: right on first, left enable rises -> left loses
    apply(1,0,2'd2, 1,0,2'd2, 1,1,0, "R2");
    chk("R2", "l_busy_n low", l_busy_n, 1'b0);
    // R3: address change onto unchanged address
    apply(1,0,2'd0, 1,0,2'd3, 1,1,0, "R3");
    apply(1,0,2'd0, 1,0,2'd0, 1,1,0, "R3");
    chk("R3", "r_busy_n low", r_busy_n, 1'b0);
    apply(1,0,2'd1, 1,0,2'd0, 1,1,0, "R4");
    apply(1,0,2'd0, 1,0,2'd0, 1,1,0, "R3");
    chk("R3", "l_busy_n low", l_busy_n, 1'b0);
    // R5: tie after both move together
    apply(1,0,2'd1, 1,0,2'd2, 1,1,0, "R5");
    apply(1,0,2'd3, 1,0,2'd3, 1,1,0, "R5");
    chk("R5", "tie left wins", r_busy_n, 1'b0);
    // R9: slave mode
    apply(1,1,2'd3, 1,1,2'd3, 0,1,1, "R9");
    chk("R9", "l_wr_go blocked", l_wr_go, 1'b0);
    apply(1,1,2'd3, 1,1,2'd3, 1,0,1, "R9");
    // sweeps: master then slave, near-exhaustive over AW=2 inputs
    lcg = 32'h1234_5678;
    for (int s = 0; s < 3000; s++) begin
      logic sm;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      sm = (s >= 2000);
      apply(lcg[31] | lcg[20], lcg[30], lcg[29:28], lcg[27] | lcg[19], lcg[26],
            lcg[25:24], lcg[23], lcg[22], sm, sm ? "sweep R9" : "sweep R1/R2/R3/R5/R6");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule